// File: doc/BRIEF.md
# Logical Immediate Bitmask Expander

This block turns a compact 13-bit immediate encoding (a size bit plus two 6-bit fields, here called `imm_n`, `imm_s` and `imm_r`) into two data-path masks. The first, the wraparound mask, is a run of S+1 ones rotated right by R inside an element of 2^len bits, copied across the whole word. The second, the top mask, is a run of ((S-R) mod 2^len)+1 ones at the bottom of each element, also copied across the word. Bitfield units use the pair to pick and merge fields. Logical-immediate units use the wraparound mask directly.

The element size comes from the position of the highest set bit in the 7-bit value formed by the size bit above the inverted `imm_s`. S and R are the two fields cut down to that size. The masks are built by a six-stage AND/OR network, with no rotator and no table. The borrow of S-R picks whether the two masks are merged by AND or by OR. A width select chooses a 64-bit or a 32-bit result. A second flag marks the logical form, which rejects the all-ones run as reserved.

Inputs are taken in one cycle and every output comes out of a register on the next rising edge. A synchronous, active-high reset clears all outputs.

Top module: `bitmask_expander`

## Requirements
- R1: All outputs are registered, so the response to the inputs sampled at one rising edge appears after that edge. While `rst` is high at an edge, `wmask_q`, `tmask_q` and `reserved_q` are all cleared to zero.
- R2: len is the index of the highest set bit of {imm_n, ~imm_s} (imm_n is bit 6). If no bit is set (imm_n=0, imm_s=6'h3f) or len is 0, `reserved_q` is 1.
- R3: If the element size 2^len exceeds the selected width, `reserved_q` is 1. With `wide`=0 (32 bits) this is every encoding with imm_n=1.
- R4: If `logical_form`=1 and imm_s AND levels equals levels (levels = len ones), `reserved_q` is 1. With `logical_form`=0 the same encoding is legal.
- R5: For an encoding whose size is legal, bit i of `wmask_q` (for i below the width) is 1 exactly when ((i mod 2^len) + R) mod 2^len <= S, where S = imm_s AND levels and R = imm_r AND levels.
- R6: For an encoding whose size is legal, bit i of `tmask_q` (for i below the width) is 1 exactly when (i mod 2^len) <= ((S-R) mod 2^len).
- R7: With `wide`=0, bits 63 down to 32 of both masks are 0.
- R8: Bits of `imm_r` at or above position len have no effect on either mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imm_n | input | 1 | Size bit of the encoding |
| imm_s | input | 6 | Run-length field |
| imm_r | input | 6 | Rotate field |
| wide | input | 1 | 1 selects a 64-bit result, 0 selects 32 bits |
| logical_form | input | 1 | 1 rejects an all-ones run as reserved |
| wmask_q | output | 64 | Registered wraparound mask |
| tmask_q | output | 64 | Registered top mask |
| reserved_q | output | 1 | Registered reserved-encoding flag |

## Verification
The assertions assume that the inputs are stable and known at each rising edge, and that an input pattern is held for one full cycle. The bench meets this by changing the inputs only on falling edges. The mask assertions apply only to encodings whose element size is legal, since the masks carry no meaning for any other encoding. The sweep covers every combination of size bit, both fields, both widths and both forms. It also compares reserved encodings, so the reserved checks see every case.

// File: rtl/bmd_pkg.sv
package bmd_pkg;

  // Width select encoding carried on the wide input.
  typedef enum logic {
    BMD_NARROW = 1'b0,
    BMD_FULL   = 1'b1
  } bmd_width_e;

  // Keep-mask that clears the upper half of a word for the narrow width.
  function automatic logic [63:0] bmd_keep64(input logic wide_sel, input int xlen);
    logic [63:0] k;
    k = '0;
    for (int i = 0; i < 64; i++) begin
      if (i < xlen) begin
        k[i] = (wide_sel == BMD_FULL) ? 1'b1 : (i < xlen / 2);
      end
    end
    return k;
  endfunction

endpackage

// File: rtl/bmd_size.sv
module bmd_size #(
  parameter int LG = 6
) (
  input  logic          n_bit,
  input  logic [LG-1:0] s_field,
  output logic          found,
  output logic [LG-1:0] len,
  output logic [LG-1:0] levels
);
  logic [LG:0] cat;

  assign cat = {n_bit, ~s_field};

  // Scan upward so that the highest set bit wins.
  always_comb begin
    found = 1'b0;
    len   = '0;
    for (int i = 0; i <= LG; i++) begin
      if (cat[i]) begin
        found = 1'b1;
        len   = LG'(i);
      end
    end
  end

  always_comb begin
    levels = '0;
    for (int i = 0; i < LG; i++) begin
      levels[i] = found && (LG'(i) < len);
    end
  end

endmodule

// File: rtl/bmd_stage.sv
module bmd_stage #(
  parameter int XLEN = 64,
  parameter int K    = 0
) (
  input  logic [XLEN-1:0] t_in,
  input  logic [XLEN-1:0] w_in,
  input  logic            t_and,
  input  logic            t_or,
  input  logic            w_and,
  input  logic            w_or,
  output logic [XLEN-1:0] t_out,
  output logic [XLEN-1:0] w_out
);
  // Each 2^(K+1)-bit group: upper half gates the top mask down and lifts the
  // wraparound mask; lower half lifts the top mask and gates the wraparound mask.
  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      if (((i >> K) & 1) == 1) begin
        t_out[i] = t_in[i] & t_and;
        w_out[i] = w_in[i] | w_or;
      end else begin
        t_out[i] = t_in[i] | t_or;
        w_out[i] = w_in[i] & w_and;
      end
    end
  end

endmodule

// File: rtl/bitmask_expander.sv
module bitmask_expander #(
  parameter int XLEN = 64,
  parameter int LG   = $clog2(XLEN)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            imm_n,
  input  logic [LG-1:0]   imm_s,
  input  logic [LG-1:0]   imm_r,
  input  logic            wide,
  input  logic            logical_form,
  output logic [XLEN-1:0] wmask_q,
  output logic [XLEN-1:0] tmask_q,
  output logic            reserved_q
);
  import bmd_pkg::*;

  localparam int HALF = XLEN / 2;

  logic          found;
  logic [LG-1:0] len;
  logic [LG-1:0] levels;
  logic [LG-1:0] s_eff;
  logic [LG-1:0] r_eff;
  logic [LG:0]   diff;
  logic          borrow;
  logic          size_ok;
  logic          reserved_c;
  logic [LG-1:0] t_and_v, t_or_v, w_and_v, w_or_v;
  logic [XLEN-1:0] tch [0:LG];
  logic [XLEN-1:0] wch [0:LG];
  logic [XLEN-1:0] keep;
  logic [XLEN-1:0] wfinal, tfinal;

  bmd_size #(.LG(LG)) u_size (
    .n_bit  (imm_n),
    .s_field(imm_s),
    .found  (found),
    .len    (len),
    .levels (levels)
  );

  assign s_eff  = imm_s & levels;
  assign r_eff  = imm_r & levels;
  assign diff   = {1'b0, s_eff} - {1'b0, r_eff};
  assign borrow = diff[LG];

  assign size_ok    = found && (len != '0) &&
                      ((wide == BMD_FULL) || (len < LG'(LG)));
  assign reserved_c = !size_ok || (logical_form && (s_eff == levels));

  assign t_and_v = diff[LG-1:0] | ~levels;
  assign t_or_v  = diff[LG-1:0] & levels;
  assign w_and_v = imm_r | ~levels;
  assign w_or_v  = imm_r & levels;

  assign tch[0] = '1;
  assign wch[0] = '0;

  for (genvar k = 0; k < LG; k++) begin : g_stage
    bmd_stage #(.XLEN(XLEN), .K(k)) u_stage (
      .t_in (tch[k]),
      .w_in (wch[k]),
      .t_and(t_and_v[k]),
      .t_or (t_or_v[k]),
      .w_and(w_and_v[k]),
      .w_or (w_or_v[k]),
      .t_out(tch[k+1]),
      .w_out(wch[k+1])
    );
  end

  always_comb begin
    for (int i = 0; i < XLEN; i++) begin
      keep[i] = (wide == BMD_FULL) || (i < HALF);
    end
  end

  assign wfinal = (borrow ? (wch[LG] & tch[LG]) : (wch[LG] | tch[LG])) & keep;
  assign tfinal = tch[LG] & keep;

  always_ff @(posedge clk) begin
    if (rst) begin
      wmask_q    <= '0;
      tmask_q    <= '0;
      reserved_q <= 1'b0;
    end else begin
      wmask_q    <= wfinal;
      tmask_q    <= tfinal;
      reserved_q <= reserved_c;
    end
  end

  // R2: no set bit in the size concatenation is always reserved
  a_r2_empty_size: assert property (@(posedge clk) disable iff (rst)
    (!imm_n && imm_s == '1) |=> reserved_q);

  // R3: size bit at the narrow width exceeds the word
  a_r3_narrow_oversize: assert property (@(posedge clk) disable iff (rst)
    (!wide && imm_n) |=> reserved_q);

  // R4: full-size all-ones run in logical form
  a_r4_logical_ones: assert property (@(posedge clk) disable iff (rst)
    (logical_form && imm_n && imm_s == '1) |=> reserved_q);

  // R4: bitfield form with a legal size is never reserved
  a_r4_bitfield_legal: assert property (@(posedge clk) disable iff (rst)
    (!logical_form && size_ok) |=> !reserved_q);

  // R6: a legal element always keeps its lowest top-mask bit
  a_r6_tmask_base: assert property (@(posedge clk) disable iff (rst)
    size_ok |=> tmask_q[0]);

  // R7: narrow results leave the upper half clear
  a_r7_narrow_upper: assert property (@(posedge clk) disable iff (rst)
    !wide |=> (wmask_q[XLEN-1:HALF] == '0 && tmask_q[XLEN-1:HALF] == '0));

endmodule

// File: tb/bitmask_expander_test.sv
module bitmask_expander_test;

  logic        clk = 1'b0;
  logic        rst;
  logic        imm_n;
  logic [5:0]  imm_s;
  logic [5:0]  imm_r;
  logic        wide;
  logic        logical_form;
  logic [63:0] wmask_q;
  logic [63:0] tmask_q;
  logic        reserved_q;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bitmask_expander uut (
    .clk(clk), .rst(rst), .imm_n(imm_n), .imm_s(imm_s), .imm_r(imm_r),
    .wide(wide), .logical_form(logical_form),
    .wmask_q(wmask_q), .tmask_q(tmask_q), .reserved_q(reserved_q)
  );

  // Model: returns -1 when no bit is set.
  function automatic int model_len(input logic n, input logic [5:0] s);
    int l;
    logic [6:0] c;
    c = {n, ~s};
    l = -1;
    for (int i = 0; i < 7; i++) if (c[i]) l = i;
    return l;
  endfunction

  task automatic chk_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s n=%0d s=%0d r=%0d wide=%0d log=%0d act=%0b exp=%0b",
               req, imm_n, imm_s, imm_r, wide, logical_form, act, exp);
    end
  endtask

  task automatic chk_word(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s n=%0d s=%0d r=%0d wide=%0d log=%0d act=%h exp=%h",
               req, imm_n, imm_s, imm_r, wide, logical_form, act, exp);
    end
  endtask

  task automatic check_vector();
    int l, es, width, sv, rv, dv;
    bit size_ok, exp_res;
    logic [63:0] we, te;
    l     = model_len(imm_n, imm_s);
    width = wide ? 64 : 32;
    size_ok = (l >= 1) && ((1 << l) <= width);
    es    = (l >= 1) ? (1 << l) : 1;
    sv    = int'(imm_s) % es;
    rv    = int'(imm_r) % es;  // R8: upper rotate bits discarded
    dv    = ((sv - rv) % es + es) % es;
    exp_res = !size_ok || (logical_form && sv == es - 1);
    // R2/R3/R4: reserved decision
    chk_bit(l < 1 ? "R2" : (size_ok ? "R4" : "R3"), reserved_q, exp_res);
    if (size_ok) begin
      we = '0;
      te = '0;
      for (int i = 0; i < width; i++) begin
        we[i] = (((i % es) + rv) % es) <= sv;
        te[i] = (i % es) <= dv;
      end
      // R5/R8 wraparound mask, R6/R7 top mask and upper half
      chk_word(wide ? "R5_R8" : "R5_R7", wmask_q, we);
      chk_word(wide ? "R6_R8" : "R6_R7", tmask_q, te);
    end
  endtask

  initial begin
    rst = 1'b1;
    imm_n = 1'b1; imm_s = 6'd5; imm_r = 6'd3; wide = 1'b1; logical_form = 1'b1;
    repeat (3) @(negedge clk);
    // R1: reset clears outputs despite active inputs
    chk_word("R1", wmask_q, 64'h0);
    chk_word("R1", tmask_q, 64'h0);
    chk_bit("R1", reserved_q, 1'b0);
    rst = 1'b0;
    for (int w = 1; w >= 0; w--) begin
      for (int lf = 0; lf < 2; lf++) begin
        for (int n = 0; n < 2; n++) begin
          for (int s = 0; s < 64; s++) begin
            for (int r = 0; r < 64; r++) begin
              imm_n = n[0]; imm_s = s[5:0]; imm_r = r[5:0];
              wide = w[0]; logical_form = lf[0];
              @(negedge clk);
              check_vector();
            end
          end
        end
      end
    end
    // R1: reset in the middle of traffic clears again on the next edge
    imm_n = 1'b0; imm_s = 6'd0; imm_r = 6'd1; wide = 1'b1; logical_form = 1'b0;
    @(negedge clk);
    chk_bit("R1", wmask_q != 64'h0, 1'b1);
    rst = 1'b1;
    @(negedge clk);
    chk_word("R1", wmask_q, 64'h0);
    chk_word("R1", tmask_q, 64'h0);
    rst = 1'b0;
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1_200_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule